// File: doc/BRIEF.md
# Receive Delay Tap Tuning Sequencer

This block searches for a working receive sampling delay for a high-speed SD/MMC card interface. After a one-cycle start pulse it walks an 8-bit delay tap upward. For each tap it asks an external command engine for one tuning-block transfer and waits for the engine's done/pass answer. The lowest passing tap becomes the window floor and the last tap of the passing run becomes the window ceiling. The block then programs a tap three quarters of the way into that window and runs one more trial there. Its result is the overall outcome.

The tap lives in an 8-bit field of a clock-control register. The block reads the current register value, replaces only the tap field and issues a write strobe. Changing the tap while the card clock runs can glitch the clock. With the guard option set, each tap change is therefore wrapped: clock off, write, settle, datapath reset pulse, clock back on. Every tuning command is also issued with the card clock held off, and the clock comes back after a settle time. The settle time is `CYC_PER_US` system clocks.

States: `ST_IDLE`, then the tap-set group `ST_SET_CAPT` → (`ST_SET_GATE` when guarded) → `ST_SET_WRITE` → (`ST_SET_SETTLE` → `ST_SET_DPRST` → `ST_SET_RESTORE` when guarded). The trial group follows: `ST_TRY_CAPT` → (`ST_TRY_GATE` when the clock runs) → `ST_TRY_CMD` → `ST_TRY_SETTLE` → (`ST_TRY_RESTORE` when the clock had been running) → `ST_TRY_WAIT` → `ST_EVAL`. From `ST_EVAL` the machine returns to `ST_SET_CAPT` with the next tap, or moves to `ST_FINISH` → `ST_IDLE`. The search phase is `PH_LOW`, `PH_HIGH` or `PH_FINAL`. `ST_IDLE` leaves only on start. `ST_SET_SETTLE` and `ST_TRY_SETTLE` leave when the settle timer expires. `ST_TRY_WAIT` leaves on a seen or arriving done.

Top module: `tts_tap_tuner`

## Requirements
- R1: A tap write puts the tap on `ctl_wdata_o[23:16]` and copies every other bit from `ctl_rdata_i` in the same cycle as `ctl_we_o`.
- R2: The low search starts at tap 10 and steps by one up to 255 inclusive. The first tap whose trial passes is the window floor.
- R3: If no tap from 10 to 255 passes, the run ends with `pass_o` = 0 after exactly 246 trials, and no high search takes place.
- R4: The high search starts at floor+1 and steps by one while trials pass. A failure at tap t makes the ceiling t−1, and a pass at 255 makes the ceiling 255. A floor of 255 skips the high search and makes the ceiling 255.
- R5: The final tap is floor + ⌊(ceiling − floor)·3/4⌋. Exactly one trial runs there, and its pass/fail is presented on `pass_o`.
- R6: With `guard_i` = 1 and the card clock on, a tap change writes the clock off, then writes the tap, waits `CYC_PER_US` cycles, pulses `dp_rst_o` for one cycle and then writes the clock on. With `guard_i` = 0 the tap is written with no gating and no `dp_rst_o`.
- R7: The card clock is written back on only if it was on when captured before gating. A clock that was off stays off, and `dp_rst_o` never pulses for that run.
- R8: Each trial's one-cycle `trial_req_o` is issued with the card clock off. After the settle time the clock is restored if it had been on.
- R9: `busy_o` is high from the cycle after start until the cycle of the one-cycle `done_o` pulse. `pass_o` holds its value until the next accepted start.
- R10: A start pulse while `busy_o` is high, including the `done_o` cycle, is ignored and does not restart or extend the run.
- R11: After reset `busy_o`, `done_o` and `pass_o` are 0 and no write strobe or request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to start a search |
| guard_i | input | 1 | Wrap tap changes in clock-off/settle/reset/clock-on |
| ctl_rdata_i | input | 32 | Current clock-control register value |
| ctl_we_o | output | 1 | Clock-control register write strobe |
| ctl_wdata_o | output | 32 | Clock-control write value with new tap field |
| cclk_en_i | input | 1 | Current card clock enable |
| cclk_we_o | output | 1 | Card clock enable write strobe |
| cclk_wval_o | output | 1 | Card clock enable value to write |
| dp_rst_o | output | 1 | One-cycle command/data datapath reset pulse |
| trial_req_o | output | 1 | One-cycle request for a tuning-block transfer |
| trial_done_i | input | 1 | One-cycle completion from the command engine |
| trial_pass_i | input | 1 | Trial outcome, valid with `trial_done_i` |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle end-of-search pulse |
| pass_o | output | 1 | Result of the last search |

## Verification
The bench builds the block with `CYC_PER_US` = 3. This keeps each settle window to a few cycles, so full sweeps of 246 trials fit easily while both settle states are still visited. The tap width and field position keep their defaults, so the ends of the search at 10 and 255 and the 75% arithmetic on an 8-bit range are exercised directly. The engine answers either inside the settle window or well after it, which covers both the latched-done path and the wait path.

// File: rtl/tts_pkg.sv
`timescale 1ns/1ps
package tts_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SET_CAPT,
        ST_SET_GATE,
        ST_SET_WRITE,
        ST_SET_SETTLE,
        ST_SET_DPRST,
        ST_SET_RESTORE,
        ST_TRY_CAPT,
        ST_TRY_GATE,
        ST_TRY_CMD,
        ST_TRY_SETTLE,
        ST_TRY_RESTORE,
        ST_TRY_WAIT,
        ST_EVAL,
        ST_FINISH
    } tts_state_e;

    typedef enum logic [1:0] {
        PH_LOW,
        PH_HIGH,
        PH_FINAL
    } tts_phase_e;

endpackage

// File: rtl/tts_settle_timer.sv
`timescale 1ns/1ps
module tts_settle_timer #(
    parameter int CYC_PER_US = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expired_o
);
    localparam int CNT_W = (CYC_PER_US > 1) ? $clog2(CYC_PER_US + 1) : 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(CYC_PER_US - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= RELOAD;
        end else if (!run_i) begin
            cnt_q <= RELOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/tts_tap_merge.sv
`timescale 1ns/1ps
module tts_tap_merge #(
    parameter int REG_W   = 32,
    parameter int TAP_W   = 8,
    parameter int TAP_LSB = 16
) (
    input  logic [REG_W-1:0] cur_i,
    input  logic [TAP_W-1:0] tap_i,
    output logic [REG_W-1:0] merged_o
);
    localparam int TAP_MSB = TAP_LSB + TAP_W - 1;

    for (genvar b = 0; b < REG_W; b++) begin : g_bit
        if (b >= TAP_LSB && b <= TAP_MSB) begin : g_field
            assign merged_o[b] = tap_i[b - TAP_LSB];
        end else begin : g_keep
            assign merged_o[b] = cur_i[b];
        end
    end
endmodule

// File: rtl/tts_window_calc.sv
`timescale 1ns/1ps
module tts_window_calc #(
    parameter int TAP_W = 8
) (
    input  logic [TAP_W-1:0] lo_i,
    input  logic [TAP_W-1:0] hi_i,
    output logic [TAP_W-1:0] pick_o
);
    logic [TAP_W-1:0] span;
    logic [TAP_W+1:0] span_x3;
    logic [TAP_W-1:0] three_q;

    always_comb begin
        span    = hi_i - lo_i;
        span_x3 = {2'b00, span} + {1'b0, span, 1'b0};
        three_q = span_x3[TAP_W+1:2];
        pick_o  = lo_i + three_q;
    end
endmodule

// File: rtl/tts_tap_tuner.sv
`timescale 1ns/1ps
module tts_tap_tuner #(
    parameter int REG_W      = 32,
    parameter int TAP_W      = 8,
    parameter int TAP_LSB    = 16,
    parameter int TAP_FLOOR  = 10,
    parameter int CYC_PER_US = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             guard_i,
    input  logic [REG_W-1:0] ctl_rdata_i,
    output logic             ctl_we_o,
    output logic [REG_W-1:0] ctl_wdata_o,
    input  logic             cclk_en_i,
    output logic             cclk_we_o,
    output logic             cclk_wval_o,
    output logic             dp_rst_o,
    output logic             trial_req_o,
    input  logic             trial_done_i,
    input  logic             trial_pass_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             pass_o
);
    import tts_pkg::*;

    localparam logic [TAP_W-1:0] TAP_TOP   = '1;
    localparam logic [TAP_W-1:0] TAP_START = TAP_W'(TAP_FLOOR);

    tts_state_e       st_q, st_d;
    tts_phase_e       ph_q;
    logic [TAP_W-1:0] tap_q;
    logic [TAP_W-1:0] floor_q;
    logic             wrap_q;
    logic             was_on_q;
    logic             seen_q;
    logic             pass_l_q;
    logic             result_q;

    logic             tmr_run;
    logic             tmr_exp;
    logic [TAP_W-1:0] calc_lo;
    logic [TAP_W-1:0] calc_hi;
    logic [TAP_W-1:0] final_tap;
    logic             at_top;

    assign at_top  = (tap_q == TAP_TOP);
    assign tmr_run = (st_q == ST_SET_SETTLE) || (st_q == ST_TRY_SETTLE);

    tts_settle_timer #(.CYC_PER_US(CYC_PER_US)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (tmr_run),
        .expired_o (tmr_exp)
    );

    tts_tap_merge #(.REG_W(REG_W), .TAP_W(TAP_W), .TAP_LSB(TAP_LSB)) u_merge (
        .cur_i    (ctl_rdata_i),
        .tap_i    (tap_q),
        .merged_o (ctl_wdata_o)
    );

    // Window edges as they will be once the current evaluation is applied.
    always_comb begin
        if (ph_q == PH_LOW) begin
            calc_lo = tap_q;
            calc_hi = tap_q;
        end else begin
            calc_lo = floor_q;
            calc_hi = pass_l_q ? tap_q : (tap_q - 1'b1);
        end
    end

    tts_window_calc #(.TAP_W(TAP_W)) u_calc (
        .lo_i   (calc_lo),
        .hi_i   (calc_hi),
        .pick_o (final_tap)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:        if (start_i) st_d = ST_SET_CAPT;
            ST_SET_CAPT:    st_d = (guard_i && cclk_en_i) ? ST_SET_GATE : ST_SET_WRITE;
            ST_SET_GATE:    st_d = ST_SET_WRITE;
            ST_SET_WRITE:   st_d = wrap_q ? ST_SET_SETTLE : ST_TRY_CAPT;
            ST_SET_SETTLE:  if (tmr_exp) st_d = ST_SET_DPRST;
            ST_SET_DPRST:   st_d = ST_SET_RESTORE;
            ST_SET_RESTORE: st_d = ST_TRY_CAPT;
            ST_TRY_CAPT:    st_d = cclk_en_i ? ST_TRY_GATE : ST_TRY_CMD;
            ST_TRY_GATE:    st_d = ST_TRY_CMD;
            ST_TRY_CMD:     st_d = ST_TRY_SETTLE;
            ST_TRY_SETTLE:  if (tmr_exp) st_d = was_on_q ? ST_TRY_RESTORE : ST_TRY_WAIT;
            ST_TRY_RESTORE: st_d = ST_TRY_WAIT;
            ST_TRY_WAIT:    if (seen_q || trial_done_i) st_d = ST_EVAL;
            ST_EVAL: begin
                unique case (ph_q)
                    PH_LOW:   st_d = (!pass_l_q && at_top) ? ST_FINISH : ST_SET_CAPT;
                    PH_HIGH:  st_d = ST_SET_CAPT;
                    PH_FINAL: st_d = ST_FINISH;
                    default:  st_d = ST_FINISH;
                endcase
            end
            ST_FINISH:      st_d = ST_IDLE;
            default:        st_d = ST_IDLE;
        endcase
    end

    // Search datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q     <= PH_LOW;
            tap_q    <= '0;
            floor_q  <= '0;
            wrap_q   <= 1'b0;
            was_on_q <= 1'b0;
            seen_q   <= 1'b0;
            pass_l_q <= 1'b0;
            result_q <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        ph_q     <= PH_LOW;
                        tap_q    <= TAP_START;
                        result_q <= 1'b0;
                    end
                end
                ST_SET_CAPT: wrap_q   <= guard_i && cclk_en_i;
                ST_TRY_CAPT: was_on_q <= cclk_en_i;
                ST_TRY_CMD:  seen_q   <= 1'b0;
                ST_TRY_SETTLE, ST_TRY_RESTORE, ST_TRY_WAIT: begin
                    if (trial_done_i && !seen_q) begin
                        seen_q   <= 1'b1;
                        pass_l_q <= trial_pass_i;
                    end
                end
                ST_EVAL: begin
                    unique case (ph_q)
                        PH_LOW: begin
                            if (pass_l_q) begin
                                floor_q <= tap_q;
                                if (at_top) begin
                                    ph_q  <= PH_FINAL;
                                    tap_q <= final_tap;
                                end else begin
                                    ph_q  <= PH_HIGH;
                                    tap_q <= tap_q + 1'b1;
                                end
                            end else if (!at_top) begin
                                tap_q <= tap_q + 1'b1;
                            end
                        end
                        PH_HIGH: begin
                            if (pass_l_q && !at_top) begin
                                tap_q <= tap_q + 1'b1;
                            end else begin
                                ph_q  <= PH_FINAL;
                                tap_q <= final_tap;
                            end
                        end
                        PH_FINAL: result_q <= pass_l_q;
                        default:  result_q <= 1'b0;
                    endcase
                end
                default: begin
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        ctl_we_o    = (st_q == ST_SET_WRITE);
        cclk_we_o   = (st_q == ST_SET_GATE) || (st_q == ST_SET_RESTORE) ||
                      (st_q == ST_TRY_GATE) || (st_q == ST_TRY_RESTORE);
        cclk_wval_o = (st_q == ST_SET_RESTORE) || (st_q == ST_TRY_RESTORE);
        dp_rst_o    = (st_q == ST_SET_DPRST);
        trial_req_o = (st_q == ST_TRY_CMD);
        busy_o      = (st_q != ST_IDLE);
        done_o      = (st_q == ST_FINISH);
        pass_o      = result_q;
    end
endmodule

// File: rtl/tts_tap_tuner_chk.sv
`timescale 1ns/1ps
module tts_tap_tuner_chk #(
    parameter int REG_W   = 32,
    parameter int TAP_W   = 8,
    parameter int TAP_LSB = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             guard_i,
    input logic [REG_W-1:0] ctl_rdata_i,
    input logic             ctl_we_o,
    input logic [REG_W-1:0] ctl_wdata_o,
    input logic             cclk_en_i,
    input logic             dp_rst_o,
    input logic             trial_req_o,
    input logic             busy_o,
    input logic             done_o
);
    localparam logic [REG_W-1:0] FIELD = {{(REG_W-TAP_W){1'b0}}, {TAP_W{1'b1}}} << TAP_LSB;

    assert_keep_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we_o |-> (((ctl_wdata_o ^ ctl_rdata_i) & ~FIELD) == '0));

    assert_guarded_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we_o && guard_i) |-> !cclk_en_i);

    assert_reset_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dp_rst_o |-> !cclk_en_i);

    assert_req_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trial_req_o |-> !cclk_en_i);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && start_i) |=> !busy_o);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!ctl_we_o && !trial_req_o && !dp_rst_o));
endmodule

bind tts_tap_tuner tts_tap_tuner_chk #(
    .REG_W   (REG_W),
    .TAP_W   (TAP_W),
    .TAP_LSB (TAP_LSB)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .guard_i     (guard_i),
    .ctl_rdata_i (ctl_rdata_i),
    .ctl_we_o    (ctl_we_o),
    .ctl_wdata_o (ctl_wdata_o),
    .cclk_en_i   (cclk_en_i),
    .dp_rst_o    (dp_rst_o),
    .trial_req_o (trial_req_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
);

// File: tb/test_tts_tap_tuner.sv
`timescale 1ns/1ps
module test_tts_tap_tuner;

    localparam int CYC    = 3;
    localparam int WD_MAX = 190000;
    localparam logic [31:0] INIT_REG = 32'h9A77_5C3E;
    localparam logic [31:0] KEEP     = 32'hFF00_FFFF;

    typedef struct packed {
        logic [7:0] lo;
        logic [7:0] hi;
        logic       guard;
        logic       clk_on;
        logic       kill;
        logic       exp_pass;
        logic [7:0] exp_tap;
        logic [8:0] exp_trials;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{8'd40,  8'd120, 1'b1, 1'b1, 1'b0, 1'b1, 8'd100, 9'd113},
        '{8'd0,   8'd30,  1'b0, 1'b1, 1'b0, 1'b1, 8'd25,  9'd23},
        '{8'd200, 8'd255, 1'b1, 1'b1, 1'b0, 1'b1, 8'd241, 9'd247},
        '{8'd255, 8'd255, 1'b1, 1'b1, 1'b0, 1'b1, 8'd255, 9'd247},
        '{8'd0,   8'd5,   1'b1, 1'b1, 1'b0, 1'b0, 8'd255, 9'd246},
        '{8'd50,  8'd50,  1'b0, 1'b0, 1'b0, 1'b1, 8'd50,  9'd43},
        '{8'd60,  8'd61,  1'b1, 1'b0, 1'b0, 1'b1, 8'd60,  9'd54},
        '{8'd60,  8'd100, 1'b1, 1'b1, 1'b1, 1'b0, 8'd90,  9'd93},
        '{8'd10,  8'd254, 1'b1, 1'b1, 1'b0, 1'b1, 8'd193, 9'd247},
        '{8'd0,   8'd255, 1'b0, 1'b1, 1'b0, 1'b1, 8'd193, 9'd247}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        guard_i = 1'b0;
    logic [31:0] ctl_q;
    logic        ctl_we_o;
    logic [31:0] ctl_wdata_o;
    logic        cclk_q;
    logic        cclk_we_o;
    logic        cclk_wval_o;
    logic        dp_rst_o;
    logic        trial_req_o;
    logic        trial_done_i = 1'b0;
    logic        trial_pass_i = 1'b0;
    logic        busy_o;
    logic        done_o;
    logic        pass_o;

    logic        preset_stb = 1'b0;
    logic [31:0] preset_ctl = '0;
    logic        preset_clk = 1'b0;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    int n_trials = 0;
    int n_dprst  = 0;
    int n_req_on = 0;
    int n_wr_on  = 0;
    int resp_wait = 0;
    logic resp_pass = 1'b0;
    int cur_lo = 0, cur_hi = 0, cur_delay = 1, kill_at = -1;

    always #2.5 clk = ~clk;

    tts_tap_tuner #(.CYC_PER_US(CYC)) i_tts_tap_tuner (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .guard_i(guard_i),
        .ctl_rdata_i(ctl_q), .ctl_we_o(ctl_we_o), .ctl_wdata_o(ctl_wdata_o),
        .cclk_en_i(cclk_q), .cclk_we_o(cclk_we_o), .cclk_wval_o(cclk_wval_o),
        .dp_rst_o(dp_rst_o), .trial_req_o(trial_req_o),
        .trial_done_i(trial_done_i), .trial_pass_i(trial_pass_i),
        .busy_o(busy_o), .done_o(done_o), .pass_o(pass_o)
    );

    // Register models for the clock-control and card clock enable registers
    always @(posedge clk) begin
        if (preset_stb) begin
            ctl_q  <= preset_ctl;
            cclk_q <= preset_clk;
        end else begin
            if (ctl_we_o)  ctl_q  <= ctl_wdata_o;
            if (cclk_we_o) cclk_q <= cclk_wval_o;
        end
    end

    // Command engine model and sequence monitors
    always @(negedge clk) begin
        int t;
        trial_done_i <= 1'b0;
        if (resp_wait > 0) begin
            resp_wait = resp_wait - 1;
            if (resp_wait == 0) begin
                trial_done_i <= 1'b1;
                trial_pass_i <= resp_pass;
            end
        end
        if (trial_req_o) begin
            n_trials = n_trials + 1;
            if (cclk_q) n_req_on = n_req_on + 1;
            t = int'(ctl_q[23:16]);
            resp_pass = (t >= cur_lo) && (t <= cur_hi) && (n_trials != kill_at);
            resp_wait = cur_delay;
        end
        if (dp_rst_o) n_dprst = n_dprst + 1;
        if (ctl_we_o && guard_i && cclk_q) n_wr_on = n_wr_on + 1;
    end

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > WD_MAX) begin
            fails = fails + 1;
            $display("FAIL watchdog: run did not finish, actual cycles %0d expected < %0d", cyc, WD_MAX);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_vec(input int idx, input vec_t v);
        int base_tr, base_dp, base_rq, base_wr, k;
        @(negedge clk);
        guard_i    = v.guard;
        preset_ctl = INIT_REG;
        preset_clk = v.clk_on;
        preset_stb = 1'b1;
        cur_lo     = int'(v.lo);
        cur_hi     = int'(v.hi);
        cur_delay  = (idx % 2 == 1) ? 1 : 6;
        base_tr = n_trials; base_dp = n_dprst; base_rq = n_req_on; base_wr = n_wr_on;
        kill_at = v.kill ? base_tr + int'(v.exp_trials) : -1;
        @(negedge clk);
        preset_stb = 1'b0;
        start_i    = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R9 busy after start", int'(busy_o), 1);
        k = 0;
        while (!done_o) begin
            start_i = (k == 40);   // R10: start while busy
            @(negedge clk);
            k = k + 1;
        end
        // done cycle: results and R10 start on the done cycle
        check("R5 final result", int'(pass_o), int'(v.exp_pass));
        check("R5 final tap field", int'(ctl_q[23:16]), int'(v.exp_tap));
        check("R1 other bits kept", int'(ctl_q & KEEP), int'(INIT_REG & KEEP));
        check("R2 R3 R4 trial count", n_trials - base_tr, int'(v.exp_trials));
        check("R6 R7 reset pulses", n_dprst - base_dp,
              (v.guard && v.clk_on) ? int'(v.exp_trials) : 0);
        check("R7 clock end state", int'(cclk_q), int'(v.clk_on));
        check("R8 req with clock on", n_req_on - base_rq, 0);
        check("R6 guarded write with clock on", n_wr_on - base_wr, 0);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R10 start on done ignored", int'(busy_o), 0);
        check("R9 done is one cycle", int'(done_o), 0);
        @(negedge clk);
        check("R10 still idle", int'(busy_o), 0);
        check("R9 result held", int'(pass_o), int'(v.exp_pass));
    endtask

    initial begin
        ctl_q  = INIT_REG;
        cclk_q = 1'b1;
        repeat (3) @(negedge clk);
        check("R11 busy in reset", int'(busy_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 busy after reset", int'(busy_o), 0);
        check("R11 done after reset", int'(done_o), 0);
        check("R11 pass after reset", int'(pass_o), 0);
        check("R11 no write strobe", int'(ctl_we_o | cclk_we_o | trial_req_o | dp_rst_o), 0);
        @(negedge clk);
        check("R11 register untouched", int'(ctl_q), int'(INIT_REG));

        for (int i = 0; i < NV; i++) begin
            run_vec(i, VECS[i]);
        end

        // Directed: guard on, clock on, window [10,10] gives floor = ceiling = 10
        run_vec(3, '{8'd10, 8'd10, 1'b1, 1'b1, 1'b0, 1'b1, 8'd10, 9'd3});
        // Directed: single passing tap below floor only, guard off, clock off
        run_vec(4, '{8'd9, 8'd9, 1'b0, 1'b0, 1'b0, 1'b0, 8'd255, 9'd246});

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule